// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block holds the two error counters of a CAN 2.0B node and works out from them whether the node is error active, error passive or bus-off. The protocol engine feeds it one-cycle strobes, one per bit-level event. A transmitter error, a bit error inside an active error flag or an overload flag, and an overlong run of dominant bits after a flag each add a fixed weight to the transmit counter. A successful transmission takes one off. A receive error adds one to the receive counter and a successful reception takes one off. When a transmitter error is flagged together with a stuff error during arbitration, it is not counted. Flag errors that follow it are still counted.

Once the transmit counter would pass the largest value it can hold, the node goes bus-off. The transmit counter is then loaded with the number of bus-free detections needed to recover, and it counts them down after software asks for recovery. While the controller is in reset mode, the counters and the warning status hold their values. During bus-off the receive counter and the warning status also hold, so the countdown cannot raise a warning interrupt on its way down. State changes and warning changes are each reported by a one-cycle interrupt pulse.

Top module: `can_fault_conf`

## Requirements
- R1: After reset both counters are 0, the state is error active, warning and bus-off are 0, no interrupt pulse is raised, and the warning limit is 96.
- R2: Each receive-error strobe adds 1 to the receive counter and each receive-success strobe subtracts 1. The counter never goes below 0 and saturates at 2^CNT_W-1. When both strobes arrive in the same cycle, the counter does not change.
- R3: In one cycle, the transmit counter first adds 8 for each of these strobes that is high: transmitter error, flag bit error, excess dominant. It then subtracts 1 if the transmit-success strobe is high and the sum is above 0.
- R4: A transmitter-error strobe that arrives together with the arbitration-stuff-error strobe adds nothing. Flag-bit-error and excess-dominant strobes in the same cycle or in later cycles still add 8 each.
- R5: The state code is 0 for error active, 1 for error passive and 2 for bus-off. Outside bus-off the state is passive when either counter is at 128 or above, and active otherwise. A transmit counter of 120 goes passive after one transmitter error.
- R6: When the result of R3 is above 2^CNT_W-1, the node enters bus-off. The transmit counter then shows 128 and the warning bit is set. The receive counter ignores its strobes for as long as the node is bus-off.
- R7: In bus-off, bus-free strobes are ignored until a recovery request is seen. After that, each bus-free strobe lowers the transmit counter by 1. The strobe that takes it to 0 returns the node to error active with both counters cleared.
- R8: While reset mode is high, every event strobe, bus-free strobe and recovery request is ignored, and both counters and the warning bit keep their values.
- R9: The warning bit is 1 when either counter is at or above the warning limit. The limit is loaded by the write strobe and takes effect from the next cycle. In bus-off the warning bit holds its value and does not follow the counters.
- R10: The state interrupt and the warning interrupt are each high for exactly the cycle in which the new state or the new warning value first appears at the outputs. Neither is high in any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reset_mode_i | input | 1 | Controller in reset mode; freezes the counters and the warning bit |
| recover_req_i | input | 1 | Request to start bus-off recovery |
| bus_free_i | input | 1 | Strobe: 11 consecutive recessive bits seen |
| tx_err_i | input | 1 | Strobe: error detected while transmitting |
| arb_stuff_err_i | input | 1 | Qualifies tx_err_i as a stuff error during arbitration |
| flag_bit_err_i | input | 1 | Strobe: bit error in an active error or overload flag |
| dom_excess_i | input | 1 | Strobe: too many dominant bits after a flag |
| tx_ok_i | input | 1 | Strobe: frame transmitted successfully |
| rx_err_i | input | 1 | Strobe: receive error |
| rx_ok_i | input | 1 | Strobe: frame received successfully |
| warn_lim_we_i | input | 1 | Write strobe for the warning limit |
| warn_lim_i | input | CNT_W (8) | New warning limit |
| tec_o | output | CNT_W (8) | Transmit error counter, or the remaining recovery count while bus-off |
| rec_o | output | CNT_W (8) | Receive error counter |
| state_o | output | 2 | Node state code (see R5) |
| warn_o | output | 1 | Error-warning status |
| busoff_o | output | 1 | Bus-off status |
| state_irq_o | output | 1 | One-cycle pulse when the state changes |
| warn_irq_o | output | 1 | One-cycle pulse when the warning bit changes |

## Verification
The assertions assume that the event strobes are single-cycle pulses from a protocol engine that sees one bit at a time, so that no more than the three weighted transmit events fall in one cycle. They also assume that reset mode is a level held for several cycles. The stimulus never raises more than those three transmit events at once and drops every strobe after one cycle. It changes reset mode only between strobes. Bus-free strobes are sent back to back during recovery, so the countdown can be followed at every step.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

   typedef enum logic [1:0] {
      FC_ACTIVE  = 2'd0,
      FC_PASSIVE = 2'd1,
      FC_BUSOFF  = 2'd2
   } fc_state_e;

endpackage

// File: rtl/can_fc_tec.sv
module can_fc_tec #(
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned ERR_INC   = 8,
   parameter int unsigned RECOV_CNT = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             freeze_i,
   input  logic             tx_err_i,
   input  logic             arb_stuff_err_i,
   input  logic             flag_bit_err_i,
   input  logic             dom_excess_i,
   input  logic             tx_ok_i,
   input  logic             recover_req_i,
   input  logic             bus_free_i,
   output logic [CNT_W-1:0] tec_q_o,
   output logic [CNT_W-1:0] tec_d_o,
   output logic             busoff_q_o,
   output logic             busoff_d_o,
   output logic             done_o
);

   localparam int unsigned SUM_W = CNT_W + 3;
   localparam logic [SUM_W-1:0] INC_S   = SUM_W'(ERR_INC);
   localparam logic [SUM_W-1:0] MAX_S   = SUM_W'((2 ** CNT_W) - 1);
   localparam logic [CNT_W-1:0] RECOV_V = CNT_W'(RECOV_CNT);
   localparam logic [CNT_W-1:0] ONE_V   = CNT_W'(1);

   logic             recov_q, recov_d;
   logic [SUM_W-1:0] inc, sum;

   always_comb begin
      tec_d_o    = tec_q_o;
      busoff_d_o = busoff_q_o;
      recov_d    = recov_q;
      done_o     = 1'b0;
      inc        = '0;
      sum        = '0;
      if (!freeze_i) begin
         if (!busoff_q_o) begin
            inc = ((tx_err_i && !arb_stuff_err_i) ? INC_S : '0)
                + (flag_bit_err_i ? INC_S : '0)
                + (dom_excess_i   ? INC_S : '0);
            sum = {{(SUM_W-CNT_W){1'b0}}, tec_q_o} + inc;
            if (tx_ok_i && (sum != '0)) sum = sum - SUM_W'(1);
            if (sum > MAX_S) begin
               busoff_d_o = 1'b1;
               tec_d_o    = RECOV_V;
            end else begin
               tec_d_o = sum[CNT_W-1:0];
            end
         end else if (!recov_q) begin
            if (recover_req_i) recov_d = 1'b1;
         end else if (bus_free_i) begin
            if (tec_q_o <= ONE_V) begin
               tec_d_o    = '0;
               busoff_d_o = 1'b0;
               recov_d    = 1'b0;
               done_o     = 1'b1;
            end else begin
               tec_d_o = tec_q_o - ONE_V;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tec_q_o    <= '0;
         busoff_q_o <= 1'b0;
         recov_q    <= 1'b0;
      end else begin
         tec_q_o    <= tec_d_o;
         busoff_q_o <= busoff_d_o;
         recov_q    <= recov_d;
      end
   end

endmodule

// File: rtl/can_fc_rec.sv
module can_fc_rec #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             freeze_i,
   input  logic             clear_i,
   input  logic             rx_err_i,
   input  logic             rx_ok_i,
   output logic [CNT_W-1:0] rec_q_o,
   output logic [CNT_W-1:0] rec_d_o
);

   localparam logic [CNT_W-1:0] MAX_V = '1;
   localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

   always_comb begin
      rec_d_o = rec_q_o;
      if (clear_i) begin
         rec_d_o = '0;
      end else if (!freeze_i) begin
         if (rx_err_i && !rx_ok_i && (rec_q_o != MAX_V))
            rec_d_o = rec_q_o + ONE_V;
         else if (rx_ok_i && !rx_err_i && (rec_q_o != '0))
            rec_d_o = rec_q_o - ONE_V;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rec_q_o <= '0;
      else        rec_q_o <= rec_d_o;
   end

endmodule

// File: rtl/can_fc_status.sv
module can_fc_status
   import can_fc_pkg::*;
#(
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned PASSIVE_LIM = 128,
   parameter int unsigned WARN_RESET  = 96,
   parameter bit          IRQ_REG     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             freeze_i,
   input  logic             lim_we_i,
   input  logic [CNT_W-1:0] lim_i,
   input  logic [CNT_W-1:0] tec_d_i,
   input  logic [CNT_W-1:0] rec_d_i,
   input  logic             busoff_q_i,
   input  logic             busoff_d_i,
   output fc_state_e        state_o,
   output logic             warn_o,
   output logic             state_irq_o,
   output logic             warn_irq_o
);

   localparam logic [CNT_W-1:0] PASS_V = CNT_W'(PASSIVE_LIM);
   localparam logic [CNT_W-1:0] WRST_V = CNT_W'(WARN_RESET);

   logic [CNT_W-1:0] lim_q;
   fc_state_e        state_d;
   logic             warn_d;

   always_comb begin
      if (busoff_d_i)                                  state_d = FC_BUSOFF;
      else if ((tec_d_i >= PASS_V) || (rec_d_i >= PASS_V)) state_d = FC_PASSIVE;
      else                                             state_d = FC_ACTIVE;

      if (freeze_i)        warn_d = warn_o;
      else if (busoff_d_i) warn_d = busoff_q_i ? warn_o : 1'b1;
      else                 warn_d = (tec_d_i >= lim_q) || (rec_d_i >= lim_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_o <= FC_ACTIVE;
         warn_o  <= 1'b0;
         lim_q   <= WRST_V;
      end else begin
         state_o <= state_d;
         warn_o  <= warn_d;
         if (lim_we_i) lim_q <= lim_i;
      end
   end

   generate
      if (IRQ_REG) begin : g_irq_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               state_irq_o <= 1'b0;
               warn_irq_o  <= 1'b0;
            end else begin
               state_irq_o <= (state_d != state_o);
               warn_irq_o  <= (warn_d != warn_o);
            end
         end
      end else begin : g_irq_comb
         assign state_irq_o = (state_d != state_o);
         assign warn_irq_o  = (warn_d != warn_o);
      end
   endgenerate

endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
   import can_fc_pkg::*;
#(
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned ERR_INC     = 8,
   parameter int unsigned PASSIVE_LIM = 128,
   parameter int unsigned RECOV_CNT   = 128,
   parameter int unsigned WARN_RESET  = 96,
   parameter bit          IRQ_REG     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reset_mode_i,
   input  logic             recover_req_i,
   input  logic             bus_free_i,
   input  logic             tx_err_i,
   input  logic             arb_stuff_err_i,
   input  logic             flag_bit_err_i,
   input  logic             dom_excess_i,
   input  logic             tx_ok_i,
   input  logic             rx_err_i,
   input  logic             rx_ok_i,
   input  logic             warn_lim_we_i,
   input  logic [CNT_W-1:0] warn_lim_i,
   output logic [CNT_W-1:0] tec_o,
   output logic [CNT_W-1:0] rec_o,
   output logic [1:0]       state_o,
   output logic             warn_o,
   output logic             busoff_o,
   output logic             state_irq_o,
   output logic             warn_irq_o
);

   localparam int unsigned CNT_MAX = (2 ** CNT_W) - 1;

   generate
      if (CNT_W < 4 || CNT_W > 16) begin : g_bad_width
         $error("CNT_W out of range");
      end
      if (RECOV_CNT < 1 || RECOV_CNT > CNT_MAX) begin : g_bad_recov
         $error("RECOV_CNT must fit the counter");
      end
      if (PASSIVE_LIM < 1 || PASSIVE_LIM > CNT_MAX) begin : g_bad_pass
         $error("PASSIVE_LIM must fit the counter");
      end
      if (WARN_RESET > CNT_MAX) begin : g_bad_warn
         $error("WARN_RESET must fit the counter");
      end
      if (ERR_INC < 1 || ERR_INC > CNT_MAX) begin : g_bad_inc
         $error("ERR_INC out of range");
      end
   endgenerate

   logic [CNT_W-1:0] tec_d, rec_d;
   logic             busoff_q, busoff_d, recov_done;
   fc_state_e        state_e;

   can_fc_tec #(
      .CNT_W    (CNT_W),
      .ERR_INC  (ERR_INC),
      .RECOV_CNT(RECOV_CNT)
   ) u_tec (
      .clk            (clk),
      .rst_n          (rst_n),
      .freeze_i       (reset_mode_i),
      .tx_err_i       (tx_err_i),
      .arb_stuff_err_i(arb_stuff_err_i),
      .flag_bit_err_i (flag_bit_err_i),
      .dom_excess_i   (dom_excess_i),
      .tx_ok_i        (tx_ok_i),
      .recover_req_i  (recover_req_i),
      .bus_free_i     (bus_free_i),
      .tec_q_o        (tec_o),
      .tec_d_o        (tec_d),
      .busoff_q_o     (busoff_q),
      .busoff_d_o     (busoff_d),
      .done_o         (recov_done)
   );

   can_fc_rec #(
      .CNT_W(CNT_W)
   ) u_rec (
      .clk     (clk),
      .rst_n   (rst_n),
      .freeze_i(reset_mode_i | busoff_q),
      .clear_i (recov_done),
      .rx_err_i(rx_err_i),
      .rx_ok_i (rx_ok_i),
      .rec_q_o (rec_o),
      .rec_d_o (rec_d)
   );

   can_fc_status #(
      .CNT_W      (CNT_W),
      .PASSIVE_LIM(PASSIVE_LIM),
      .WARN_RESET (WARN_RESET),
      .IRQ_REG    (IRQ_REG)
   ) u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .freeze_i   (reset_mode_i),
      .lim_we_i   (warn_lim_we_i),
      .lim_i      (warn_lim_i),
      .tec_d_i    (tec_d),
      .rec_d_i    (rec_d),
      .busoff_q_i (busoff_q),
      .busoff_d_i (busoff_d),
      .state_o    (state_e),
      .warn_o     (warn_o),
      .state_irq_o(state_irq_o),
      .warn_irq_o (warn_irq_o)
   );

   assign state_o  = state_e;
   assign busoff_o = busoff_q;

endmodule

// File: rtl/can_fc_chk.sv
module can_fc_chk #(
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned RECOV_CNT = 128,
   parameter bit          IRQ_REG   = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reset_mode_i,
   input logic [CNT_W-1:0] tec_o,
   input logic [CNT_W-1:0] rec_o,
   input logic [1:0]       state_o,
   input logic             warn_o,
   input logic             busoff_o,
   input logic             state_irq_o
);

   localparam logic [CNT_W-1:0] RECOV_V = CNT_W'(RECOV_CNT);

   AST_REC_FROZEN_RST: assert property (@(posedge clk) disable iff (!rst_n)
      reset_mode_i |=> $stable(rec_o));                                        // R8
   AST_TEC_FROZEN_RST: assert property (@(posedge clk) disable iff (!rst_n)
      reset_mode_i |=> $stable(tec_o));                                        // R8
   AST_WARN_FROZEN_RST: assert property (@(posedge clk) disable iff (!rst_n)
      reset_mode_i |=> $stable(warn_o));                                       // R8
   AST_REC_FROZEN_BUSOFF: assert property (@(posedge clk) disable iff (!rst_n)
      busoff_o |=> ($stable(rec_o) || (!busoff_o && rec_o == '0)));            // R6
   AST_WARN_HELD_BUSOFF: assert property (@(posedge clk) disable iff (!rst_n)
      busoff_o |=> ($stable(warn_o) || !busoff_o));                            // R9
   AST_BUSOFF_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busoff_o) |-> (tec_o == RECOV_V && warn_o && state_o == 2'd2));    // R6
   AST_RECOVERY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busoff_o) |-> (tec_o == '0 && rec_o == '0 && state_o == 2'd0));   // R7
   AST_TEC_RECOV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      busoff_o |-> (tec_o <= RECOV_V && tec_o != '0));                         // R7
   AST_LEGAL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      state_o != 2'd3);                                                        // R5

   generate
      if (IRQ_REG) begin : g_irq_chk
         AST_STATE_IRQ_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
            state_irq_o |-> (state_o != $past(state_o)));                      // R10
         AST_STATE_NO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            !state_irq_o |-> (state_o == $past(state_o)));                     // R10
      end
   endgenerate

endmodule

bind can_fault_conf can_fc_chk #(
   .CNT_W    (CNT_W),
   .RECOV_CNT(RECOV_CNT),
   .IRQ_REG  (IRQ_REG)
) u_can_fc_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reset_mode_i(reset_mode_i),
   .tec_o       (tec_o),
   .rec_o       (rec_o),
   .state_o     (state_o),
   .warn_o      (warn_o),
   .busoff_o    (busoff_o),
   .state_irq_o (state_irq_o)
);

// File: tb/test_can_fault_conf.sv
`timescale 1ns/1ps
module test_can_fault_conf;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reset_mode = 1'b0, recover_req = 1'b0, bus_free = 1'b0;
   logic       tx_err = 1'b0, arb = 1'b0, flag_be = 1'b0, dom_ex = 1'b0;
   logic       tx_ok = 1'b0, rx_err = 1'b0, rx_ok = 1'b0;
   logic       lim_we = 1'b0;
   logic [7:0] lim = 8'd0;
   logic [7:0] tec, rec;
   logic [1:0] state;
   logic       warn, busoff, state_irq, warn_irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   can_fault_conf i_can_fault_conf (
      .clk(clk), .rst_n(rst_n), .reset_mode_i(reset_mode), .recover_req_i(recover_req),
      .bus_free_i(bus_free), .tx_err_i(tx_err), .arb_stuff_err_i(arb),
      .flag_bit_err_i(flag_be), .dom_excess_i(dom_ex), .tx_ok_i(tx_ok),
      .rx_err_i(rx_err), .rx_ok_i(rx_ok), .warn_lim_we_i(lim_we), .warn_lim_i(lim),
      .tec_o(tec), .rec_o(rec), .state_o(state), .warn_o(warn), .busoff_o(busoff),
      .state_irq_o(state_irq), .warn_irq_o(warn_irq)
   );

   // stimulus {tx_err, arb, flag_be, dom_ex, tx_ok, rx_err, rx_ok}, tec, rec, state, warn
   localparam logic [25:0] VEC [0:13] = '{
      {7'b0000010, 8'd0,  8'd1, 2'd0, 1'b0},
      {7'b0000010, 8'd0,  8'd2, 2'd0, 1'b0},
      {7'b0000001, 8'd0,  8'd1, 2'd0, 1'b0},
      {7'b0000001, 8'd0,  8'd0, 2'd0, 1'b0},
      {7'b0000001, 8'd0,  8'd0, 2'd0, 1'b0},
      {7'b1000000, 8'd8,  8'd0, 2'd0, 1'b0},
      {7'b1100000, 8'd8,  8'd0, 2'd0, 1'b0},  // R4: suppressed
      {7'b0010000, 8'd16, 8'd0, 2'd0, 1'b0},
      {7'b0001000, 8'd24, 8'd0, 2'd0, 1'b0},
      {7'b0000100, 8'd23, 8'd0, 2'd0, 1'b0},
      {7'b1000100, 8'd30, 8'd0, 2'd0, 1'b0},
      {7'b1011000, 8'd54, 8'd0, 2'd0, 1'b0},
      {7'b1110000, 8'd62, 8'd0, 2'd0, 1'b0},  // R4: flag error still counts
      {7'b0000110, 8'd61, 8'd1, 2'd0, 1'b0}
   };

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
      {tx_err, arb, flag_be, dom_ex, tx_ok, rx_err, rx_ok} = '0;
      bus_free = 1'b0; recover_req = 1'b0; lim_we = 1'b0;
   endtask

   initial begin
      int wirq;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R1", "tec", tec, 0);
      check("R1", "rec", rec, 0);
      check("R1", "state", state, 0);
      check("R1", "warn", warn, 0);
      check("R1", "busoff", busoff, 0);
      check("R1", "irqs", {state_irq, warn_irq}, 0);

      for (int i = 0; i < 14; i++) begin
         {tx_err, arb, flag_be, dom_ex, tx_ok, rx_err, rx_ok} = VEC[i][25:19];
         cyc();
         check("R3", "tec vector", tec, VEC[i][18:11]);
         check("R2", "rec vector", rec, VEC[i][10:3]);
         check("R5", "state vector", state, VEC[i][2:1]);
         check("R9", "warn vector", warn, VEC[i][0]);
      end

      // R9 programmable limit, effective one cycle after the write
      lim_we = 1'b1; lim = 8'd60; cyc();
      check("R9", "warn same cycle as write", warn, 0);
      cyc();
      check("R9", "warn with limit 60", warn, 1);
      check("R10", "warn irq on rise", warn_irq, 1);
      cyc();
      check("R10", "warn irq single cycle", warn_irq, 0);
      lim_we = 1'b1; lim = 8'd96; cyc(); cyc();
      check("R9", "warn back off", warn, 0);

      // R8 reset mode freezes everything
      reset_mode = 1'b1;
      tx_err = 1'b1; rx_err = 1'b1; flag_be = 1'b1; cyc();
      check("R8", "tec frozen", tec, 61);
      check("R8", "rec frozen", rec, 1);
      lim_we = 1'b1; lim = 8'd10; cyc(); cyc();
      check("R8", "warn frozen", warn, 0);
      reset_mode = 1'b0; cyc();
      check("R8", "warn follows after reset mode", warn, 1);
      lim_we = 1'b1; lim = 8'd96; cyc(); cyc();
      check("R9", "warn restored", warn, 0);

      // R5 passive threshold
      repeat (5) begin tx_ok = 1'b1; cyc(); end
      repeat (8) begin flag_be = 1'b1; cyc(); end
      check("R3", "tec at 120", tec, 120);
      tx_err = 1'b1; cyc();
      check("R5", "tec 128", tec, 128);
      check("R5", "passive at 128", state, 1);
      check("R10", "state irq to passive", state_irq, 1);
      tx_ok = 1'b1; cyc();
      check("R5", "active at 127", state, 0);
      check("R10", "state irq to active", state_irq, 1);
      tx_err = 1'b1; cyc();
      repeat (5) begin tx_err = 1'b1; flag_be = 1'b1; dom_ex = 1'b1; cyc(); end
      check("R3", "tec at 255", tec, 255);
      check("R6", "not bus-off at 255", busoff, 0);

      // R6 bus-off entry
      tx_err = 1'b1; cyc();
      check("R6", "busoff", busoff, 1);
      check("R6", "tec recovery count", tec, 128);
      check("R6", "state busoff", state, 2);
      check("R6", "warn set", warn, 1);
      rx_err = 1'b1; cyc();
      check("R6", "rec frozen in busoff", rec, 1);

      // R7 recovery
      bus_free = 1'b1; cyc();
      check("R7", "bus-free ignored before request", tec, 128);
      recover_req = 1'b1; cyc();
      wirq = 0;
      repeat (10) begin bus_free = 1'b1; cyc(); if (warn_irq) wirq++; end
      check("R7", "tec after 10", tec, 118);
      reset_mode = 1'b1; bus_free = 1'b1; cyc();
      check("R8", "recovery frozen", tec, 118);
      reset_mode = 1'b0;
      repeat (117) begin bus_free = 1'b1; cyc(); if (warn_irq) wirq++; end
      check("R7", "tec at 1", tec, 1);
      check("R7", "still busoff", busoff, 1);
      check("R9", "warn held during recovery", warn, 1);
      check("R9", "no warn irq during recovery", wirq, 0);
      bus_free = 1'b1; cyc();
      check("R7", "tec cleared", tec, 0);
      check("R7", "rec cleared", rec, 0);
      check("R7", "active", state, 0);
      check("R7", "busoff cleared", busoff, 0);
      check("R10", "state irq on exit", state_irq, 1);
      check("R10", "warn irq on exit", warn_irq, 1);

      // R2 and R9 with the default limit of 96
      repeat (95) begin rx_err = 1'b1; cyc(); end
      check("R1", "warn below default limit", warn, 0);
      rx_err = 1'b1; cyc();
      check("R1", "warn at default limit 96", warn, 1);
      repeat (32) begin rx_err = 1'b1; cyc(); end
      check("R5", "rec 128 passive", state, 1);
      repeat (130) begin rx_err = 1'b1; cyc(); end
      check("R2", "rec saturates", rec, 255);
      rx_err = 1'b1; rx_ok = 1'b1; cyc();
      check("R2", "both strobes no change", rec, 255);
      rx_ok = 1'b1; cyc();
      check("R2", "rec decrements from max", rec, 254);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule